// File: doc/BRIEF.md
# 256-bit In-Lane Vector Shuffle Unit

This block rearranges the data of two 256-bit source vectors under control of an opcode and an 8-bit immediate. It offers five operations. The first is a low-half interleave of 32-bit elements, done separately inside each 128-bit lane. The second is an any-to-any permute of 64-bit elements across the full width. The third widens sixteen bytes into zero-extended 16-bit words. The last two shift each 64-bit element on its own, one to the left and one to the right. The per-element count for each shift comes from the second source.

A request is given by a valid strobe together with the opcode, both sources and the immediate. The result is captured in a register and shown with a valid flag on the following clock. The valid flag is driven by a two-state controller. **ST_EMPTY** means no result is being presented. **ST_FULL** means the result register holds the answer to the request of the previous cycle. The controller has four transitions:
- *accept*: ST_EMPTY to ST_FULL on a request.
- *stream*: ST_FULL stays in ST_FULL on a request.
- *drain*: ST_FULL to ST_EMPTY with no request.
- *idle*: ST_EMPTY stays in ST_EMPTY with no request.

Top module: `vshuf_unit`

## Requirements
- R1: While synchronous active-high reset is high, out_valid is 0 and result is all zero from the next clock edge.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 in the cycle after a cycle with in_valid low.
- R3: Opcode 0 interleaves the low halves lane by lane. Number the 32-bit dwords of src_a A..H and those of src_b I..P, with A and I at bits [31:0]. The result dwords from lowest to highest are then A, I, B, J, E, M, F, N. No data crosses bit 128.
- R4: Opcode 1 sets result qword k (bits [64k+63:64k]) to src_a qword imm[2k+1:2k]. One source qword may appear in several destinations.
- R5: Opcode 2 sets result word i (bits [16i+15:16i]) to byte i of src_a[127:0] with the upper 8 bits zero. src_a[255:128] has no effect.
- R6: Opcode 3 shifts each 64-bit element of src_a left by the unsigned 64-bit count in the matching element of src_b. A count of 64 or more gives zero.
- R7: Opcode 4 works like R6 but shifts right logically, filling with zeros.
- R8: Opcodes 5, 6 and 7 produce an all-zero result, with out_valid still set.
- R9: With in_valid low, the result holds its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 3 | Operation select (0..4 defined) |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector / shift counts |
| imm | input | 8 | Permute selector fields |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 256 | Registered result |

## Verification
A new request can be captured in the same cycle that the previous result is being presented. This is the stream transition. The bench issues requests back to back with a changing opcode each cycle, and judges every presented result against its own request only. A second pairing puts both shift boundaries into one request: elements with counts 63 and 64, and a huge count, sit beside each other. Each element is then compared separately, through the whole-vector comparison, against the bench's own model.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
    localparam int VEC_W  = 256;
    localparam int LANE_W = 128;
    localparam int OPC_W  = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_UNPCKLO = 3'd0,
        OP_QPERM   = 3'd1,
        OP_WIDEN   = 3'd2,
        OP_SHL     = 3'd3,
        OP_SHR     = 3'd4
    } opc_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } vld_state_e;
endpackage

// File: rtl/vshuf_unpack_lo.sv
// Lane-split low interleave: each lane takes its lower half elements of
// both sources and alternates them, first source first.
module vshuf_unpack_lo #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128,
    parameter int ELEM_W = 32
) (
    input  logic [VEC_W/2-1:0] a_lo,   // low half of every lane, lanes packed
    input  logic [VEC_W/2-1:0] b_lo,
    output logic [VEC_W-1:0]   y
);
    localparam int NUM_LANES = VEC_W / LANE_W;
    localparam int HALF_W    = LANE_W / 2;
    localparam int HALF_ELEM = HALF_W / ELEM_W;

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        for (genvar e = 0; e < HALF_ELEM; e++) begin : g_elem
            assign y[ln*LANE_W + (2*e)*ELEM_W   +: ELEM_W] = a_lo[ln*HALF_W + e*ELEM_W +: ELEM_W];
            assign y[ln*LANE_W + (2*e+1)*ELEM_W +: ELEM_W] = b_lo[ln*HALF_W + e*ELEM_W +: ELEM_W];
        end
    end
endmodule

// File: rtl/vshuf_qperm.sv
// Full-width element permute: each destination picks any source element.
module vshuf_qperm #(
    parameter int VEC_W  = 256,
    parameter int ELEM_W = 64
) (
    input  logic [VEC_W-1:0]                                 a,
    input  logic [(VEC_W/ELEM_W)*$clog2(VEC_W/ELEM_W)-1:0] sel,
    output logic [VEC_W-1:0]                                 y
);
    localparam int NUM_ELEM = VEC_W / ELEM_W;
    localparam int SEL_W    = $clog2(NUM_ELEM);

    for (genvar k = 0; k < NUM_ELEM; k++) begin : g_dst
        logic [SEL_W-1:0] s;
        assign s = sel[k*SEL_W +: SEL_W];
        assign y[k*ELEM_W +: ELEM_W] = a[s*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/vshuf_widen.sv
// Zero-extending widen of narrow elements to double width.
module vshuf_widen #(
    parameter int OUT_W = 256,
    parameter int NAR_W = 8
) (
    input  logic [OUT_W/2-1:0] a,
    output logic [OUT_W-1:0]   y
);
    localparam int WIDE_W = 2 * NAR_W;
    localparam int COUNT  = OUT_W / WIDE_W;

    for (genvar i = 0; i < COUNT; i++) begin : g_elem
        assign y[i*WIDE_W +: WIDE_W] = {{NAR_W{1'b0}}, a[i*NAR_W +: NAR_W]};
    end
endmodule

// File: rtl/vshuf_varshift.sv
// Per-element logical shift; direction chosen by parameter.
module vshuf_varshift #(
    parameter int VEC_W      = 256,
    parameter int ELEM_W     = 64,
    parameter bit SHIFT_LEFT = 1'b1
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] cnt,
    output logic [VEC_W-1:0] y
);
    localparam int NUM_ELEM = VEC_W / ELEM_W;
    localparam int AMT_W    = $clog2(ELEM_W);

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        logic [ELEM_W-1:0] c;
        logic              too_big;
        logic [AMT_W-1:0]  amt;
        logic [ELEM_W-1:0] sh;
        assign c       = cnt[e*ELEM_W +: ELEM_W];
        assign too_big = |c[ELEM_W-1:AMT_W];
        assign amt     = c[AMT_W-1:0];
        if (SHIFT_LEFT) begin : g_left
            assign sh = a[e*ELEM_W +: ELEM_W] << amt;
        end else begin : g_right
            assign sh = a[e*ELEM_W +: ELEM_W] >> amt;
        end
        assign y[e*ELEM_W +: ELEM_W] = too_big ? '0 : sh;
    end
endmodule

// File: rtl/vshuf_unit.sv
module vshuf_unit
    import vshuf_pkg::*;
#(
    parameter int IMM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);
    localparam int NUM_LANES = VEC_W / LANE_W;
    localparam int HALF_W    = LANE_W / 2;

    vld_state_e state_q, state_d;

    logic [VEC_W/2-1:0] a_lo, b_lo;
    logic [VEC_W-1:0]   r_unp, r_perm, r_wide, r_shl, r_shr;
    logic [VEC_W-1:0]   r_sel;

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_half
        assign a_lo[ln*HALF_W +: HALF_W] = src_a[ln*LANE_W +: HALF_W];
        assign b_lo[ln*HALF_W +: HALF_W] = src_b[ln*LANE_W +: HALF_W];
    end

    vshuf_unpack_lo #(.VEC_W(VEC_W), .LANE_W(LANE_W), .ELEM_W(32)) u_unp (
        .a_lo(a_lo), .b_lo(b_lo), .y(r_unp)
    );

    vshuf_qperm #(.VEC_W(VEC_W), .ELEM_W(64)) u_perm (
        .a(src_a), .sel(imm), .y(r_perm)
    );

    vshuf_widen #(.OUT_W(VEC_W), .NAR_W(8)) u_wide (
        .a(src_a[VEC_W/2-1:0]), .y(r_wide)
    );

    vshuf_varshift #(.VEC_W(VEC_W), .ELEM_W(64), .SHIFT_LEFT(1'b1)) u_shl (
        .a(src_a), .cnt(src_b), .y(r_shl)
    );

    vshuf_varshift #(.VEC_W(VEC_W), .ELEM_W(64), .SHIFT_LEFT(1'b0)) u_shr (
        .a(src_a), .cnt(src_b), .y(r_shr)
    );

    always_comb begin
        unique case (opc_e'(opcode))
            OP_UNPCKLO: r_sel = r_unp;
            OP_QPERM:   r_sel = r_perm;
            OP_WIDEN:   r_sel = r_wide;
            OP_SHL:     r_sel = r_shl;
            OP_SHR:     r_sel = r_shr;
            default:    r_sel = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Next state: accept / stream / drain / idle
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst)           result <= '0;
        else if (in_valid) result <= r_sel;
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/vshuf_unit_chk.sv
module vshuf_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [2:0]   opcode,
    input logic [63:0]  cnt0,
    input logic [63:0]  cnt3,
    input logic         out_valid,
    input logic [255:0] result
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!out_valid && result == '0));
    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    // R8
    a_r8_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode > 3'd4) |=> (result == '0 && out_valid));
    // R5
    a_r5_widen_zero_top: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd2) |=> (result[15:8] == 8'h00 && result[255:248] == 8'h00));
    // R6
    a_r6_big_count_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd3 && cnt0 >= 64'd64) |=> (result[63:0] == '0));
    // R7
    a_r7_big_count_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd4 && cnt3 >= 64'd64) |=> (result[255:192] == '0));
endmodule

bind vshuf_unit vshuf_unit_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .cnt0(src_b[63:0]), .cnt3(src_b[255:192]),
    .out_valid(out_valid), .result(result)
);

// File: tb/vshuf_unit_tb.sv
module vshuf_unit_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   opcode = '0;
    logic [255:0] src_a = '0, src_b = '0;
    logic [7:0]   imm = '0;
    logic         out_valid;
    logic [255:0] result;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    vshuf_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [63:0] rnd_cnt();
        case ($urandom % 4)
            0:       return {$urandom, $urandom};
            1:       return 64'd60 + 64'($urandom % 8);
            default: return 64'($urandom % 64);
        endcase
    endfunction

    function automatic logic [255:0] model(input logic [2:0] op, input logic [255:0] a, b,
                                           input logic [7:0] im);
        logic [255:0] r;
        logic [63:0]  c;
        r = '0;
        case (op)
            3'd0: r = {b[191:160], a[191:160], b[159:128], a[159:128],
                       b[63:32],   a[63:32],   b[31:0],    a[31:0]};
            3'd1: for (int k = 0; k < 4; k++) r[64*k +: 64] = a[64*im[2*k +: 2] +: 64];
            3'd2: for (int i = 0; i < 16; i++) r[16*i +: 16] = {8'h00, a[8*i +: 8]};
            3'd3, 3'd4:
                for (int e = 0; e < 4; e++) begin
                    c = b[64*e +: 64];
                    if (c >= 64) r[64*e +: 64] = '0;
                    else if (op == 3'd3) r[64*e +: 64] = a[64*e +: 64] << c;
                    else r[64*e +: 64] = a[64*e +: 64] >> c;
                end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3 unpack-low";
            3'd1: return "R4 permute";
            3'd2: return "R5 widen";
            3'd3: return "R6 shift-left";
            3'd4: return "R7 shift-right";
            default: return "R8 unknown-op";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request; check the result presented one clock later.
    task automatic run_op(input logic [2:0] op, input logic [255:0] a, b, input logic [7:0] im);
        opcode = op; src_a = a; src_b = b; imm = im; in_valid = 1'b1;
        @(negedge clk);
        chk(tag_of(op), result, model(op, a, b, im));
        chk("R2 valid after request", 256'(out_valid), 256'd1);
    endtask

    task automatic idle_check();
        logic [255:0] keep;
        keep = result;
        in_valid = 1'b0; opcode = 3'($urandom); src_a = rnd256(); src_b = rnd256(); imm = 8'($urandom);
        @(negedge clk);
        chk("R2 valid drops", 256'(out_valid), 256'd0);
        chk("R9 result holds", result, keep);
    endtask

    initial begin
        logic [255:0] a, b;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 256'(out_valid), 256'd0);
        chk("R1 reset result", result, '0);
        rst = 1'b0;

        // R3: labelled dwords A..H = 0xA0..0xA7, I..P = 0xB0..0xB7
        for (int i = 0; i < 8; i++) begin a[32*i +: 32] = 32'hA0 + i; b[32*i +: 32] = 32'hB0 + i; end
        run_op(3'd0, a, b, 8'h00);
        chk("R3 lane order A I B J E M F N", result,
            {32'hB5, 32'hA5, 32'hB4, 32'hA4, 32'hB1, 32'hA1, 32'hB0, 32'hA0});
        // R4: broadcast and reverse
        a = rnd256();
        run_op(3'd1, a, rnd256(), 8'h00);
        chk("R4 broadcast", result, {4{a[63:0]}});
        run_op(3'd1, a, rnd256(), 8'h1B);
        chk("R4 reverse", result, {a[63:0], a[127:64], a[191:128], a[255:192]});
        // R5: upper half of source must not matter
        a = rnd256();
        run_op(3'd2, a, '0, 8'h00);
        run_op(3'd2, {~a[255:128], a[127:0]}, '0, 8'h00);
        // R6/R7: counts 0, 63, 64, huge in one request
        b = {64'hFFFF_0000_0000_0001, 64'd64, 64'd63, 64'd0};
        run_op(3'd3, {4{64'hFFFF_FFFF_FFFF_FFFF}}, b, 8'h00);
        run_op(3'd4, {4{64'hFFFF_FFFF_FFFF_FFFF}}, b, 8'h00);
        // R8: every undefined opcode
        for (int op = 5; op < 8; op++) run_op(3'(op), rnd256(), rnd256(), 8'hFF);
        idle_check();
        idle_check();

        // Random back-to-back stream with occasional idles
        for (int n = 0; n < 400; n++) begin
            logic [2:0] op;
            op = 3'($urandom % 8);
            b = rnd256();
            if (op == 3'd3 || op == 3'd4)
                for (int e = 0; e < 4; e++) b[64*e +: 64] = rnd_cnt();
            run_op(op, rnd256(), b, 8'($urandom));
            if ($urandom % 8 == 0) idle_check();
        end
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 200000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule